// File: doc/BRIEF.md
# Infrared FIFO DMA Request Generator

This block drives the single DMA request line of an infrared serial controller. It watches the fill level of the receive FIFO and the fill level of the transmit FIFO. It compares one of them against a programmable threshold and raises a request toward the one DMA channel that both directions share. A routing bit decides which direction owns that channel: the receiver by default, or the transmitter. The threshold comes from a one-bit level select and, for transmit, also from the FIFO depth in use (16 or 32 entries).

An optional fairness timer stops one device from holding the bus. While it is enabled, a request that stays active for 10.5 microseconds is dropped for one clock, which lets other masters win arbitration. Clearing the fairness enable removes the limit. A loopback control also produces two registered routing outputs. One tells the receive path to take its data from the transmitter. The other gates the transmit line driver: while loopback is on, the transmitter keeps driving the line only if the channel is routed to the transmit side.

Top module: `ir_dma_req`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `dreq` is 0, `rx_from_tx` is 0 and `tx_line_en` is 1.
- R2: With `chan_tx` = 0 (receive owns the channel), `dreq` one clock later is 1 exactly when `rx_level` is at least the receive threshold. That threshold is 4 when `thr_sel` = 0 and 10 when `thr_sel` = 1, for either depth. The fairness release of R6 is the only exception.
- R3: With `chan_tx` = 1, `dreq` one clock later is 1 exactly when the free space (depth − `tx_level`) is at least the transmit threshold. The depth is 16 when `deep` = 0 and 32 when `deep` = 1. The fairness release of R6 is the only exception.
- R4: The transmit threshold is 13 (`thr_sel` = 0) or 7 (`thr_sel` = 1) at depth 16, and 23 (`thr_sel` = 0) or 13 (`thr_sel` = 1) at depth 32.
- R5: The level of the direction that does not own the channel has no effect on `dreq`.
- R6: With `fair_off` = 0, `dreq` is never high for more than 252 consecutive clocks (10.5 µs at the default 24 MHz). After 252 high clocks it is low for exactly one clock. It is high again on the next clock if the condition still holds.
- R7: With `fair_off` = 1, `dreq` stays high for as long as the condition holds, with no limit.
- R8: `rx_from_tx` equals the value `loop_all` had one clock earlier.
- R9: `tx_line_en` one clock later is 1 when `loop_all` was 0, and equals `chan_tx` when `loop_all` was 1.
- R10: `dreq` falls on the clock after the selected condition stops holding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | 6 | Entries held in the receive FIFO |
| tx_level | input | 6 | Entries held in the transmit FIFO |
| deep | input | 1 | FIFO depth: 0 = 16, 1 = 32 |
| thr_sel | input | 1 | Threshold level select |
| fair_off | input | 1 | 1 disables the fairness timeout |
| chan_tx | input | 1 | Channel owner: 0 receive, 1 transmit |
| loop_all | input | 1 | Loopback in every mode |
| dreq | output | 1 | Registered DMA request |
| rx_from_tx | output | 1 | Receive path takes data from the transmitter |
| tx_line_en | output | 1 | Transmit line driver enable |

## Verification
The checks assume that each FIFO level never exceeds the selected depth, because free space is computed as depth minus level and has no meaning beyond it. The stimulus picks the depth first and then draws each level from zero up to that depth, including both end points. The fairness checks assume `fair_off` is sampled on the same edge as the request condition. The long directed holds therefore keep every control stable for more than 252 clocks, so that forced releases and unlimited holds can both be observed.

// File: rtl/ir_dma_pkg.sv
package ir_dma_pkg;

  typedef enum logic {
    CH_RX = 1'b0,
    CH_TX = 1'b1
  } dma_owner_e;

  typedef struct packed {
    logic rx_from_tx;
    logic tx_line_en;
  } loop_route_t;

  // Number of system clocks in 10.5 us, from the clock rate in kHz.
  function automatic int fair_cycles(input int clk_khz);
    return (clk_khz * 105) / 10000;
  endfunction

endpackage

// File: rtl/ir_dma_thresh.sv
module ir_dma_thresh #(
  parameter int DEPTH_SMALL = 16,
  parameter int DEPTH_LARGE = 32,
  parameter int RX_THR_LO   = 4,
  parameter int RX_THR_HI   = 10,
  parameter int TX_THR_S0   = 13,
  parameter int TX_THR_S1   = 7,
  parameter int TX_THR_L0   = 23,
  parameter int TX_THR_L1   = 13,
  parameter int LVL_W       = $clog2(DEPTH_LARGE + 1)
) (
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             deep,
  input  logic             thr_sel,
  output logic             rx_hit,
  output logic             tx_hit
);

  localparam logic [LVL_W-1:0] D_S  = LVL_W'(DEPTH_SMALL);
  localparam logic [LVL_W-1:0] D_L  = LVL_W'(DEPTH_LARGE);
  localparam logic [LVL_W-1:0] R_LO = LVL_W'(RX_THR_LO);
  localparam logic [LVL_W-1:0] R_HI = LVL_W'(RX_THR_HI);

  logic [LVL_W-1:0] depth;
  logic [LVL_W-1:0] rx_thr;
  logic [LVL_W-1:0] tx_thr;
  logic [LVL_W-1:0] tx_free;

  // One transmit table per depth; the depth bit picks a row.
  logic [LVL_W-1:0] tx_row [2];
  logic [LVL_W-1:0] tx_row_s [2];

  for (genvar g = 0; g < 2; g++) begin : g_tx_row
    localparam int LEV0 = (g == 0) ? TX_THR_S0 : TX_THR_L0;
    localparam int LEV1 = (g == 0) ? TX_THR_S1 : TX_THR_L1;
    assign tx_row[g]   = LVL_W'(LEV0);
    assign tx_row_s[g] = LVL_W'(LEV1);
  end

  always_comb begin
    depth   = deep ? D_L : D_S;
    rx_thr  = thr_sel ? R_HI : R_LO;
    tx_thr  = thr_sel ? tx_row_s[deep] : tx_row[deep];
    tx_free = depth - tx_level;
    rx_hit  = (rx_level >= rx_thr);
    tx_hit  = (tx_free >= tx_thr);
  end

endmodule

// File: rtl/ir_dma_fair.sv
module ir_dma_fair #(
  parameter int HOLD_CYC = 252,
  parameter int CNT_W    = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  input  logic fair_en,
  output logic dreq
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] run_cnt;
  logic             expire;

  assign expire = dreq && fair_en && (run_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      dreq    <= 1'b0;
      run_cnt <= '0;
    end else if (expire) begin
      dreq    <= 1'b0;
      run_cnt <= '0;
    end else begin
      dreq    <= cond;
      run_cnt <= (dreq && cond && fair_en) ? run_cnt + 1'b1 : '0;
    end
  end

endmodule

// File: rtl/ir_dma_route.sv
module ir_dma_route
  import ir_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        loop_all,
  input  dma_owner_e  owner,
  output loop_route_t route
);

  loop_route_t route_d;

  always_comb begin
    route_d.rx_from_tx = loop_all;
    route_d.tx_line_en = !loop_all || (owner == CH_TX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route.rx_from_tx <= 1'b0;
      route.tx_line_en <= 1'b1;
    end else begin
      route <= route_d;
    end
  end

endmodule

// File: rtl/ir_dma_req.sv
module ir_dma_req
  import ir_dma_pkg::*;
#(
  parameter int CLK_KHZ     = 24000,
  parameter int DEPTH_SMALL = 16,
  parameter int DEPTH_LARGE = 32,
  parameter int RX_THR_LO   = 4,
  parameter int RX_THR_HI   = 10,
  parameter int TX_THR_S0   = 13,
  parameter int TX_THR_S1   = 7,
  parameter int TX_THR_L0   = 23,
  parameter int TX_THR_L1   = 13,
  parameter int LVL_W       = $clog2(DEPTH_LARGE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             deep,
  input  logic             thr_sel,
  input  logic             fair_off,
  input  logic             chan_tx,
  input  logic             loop_all,
  output logic             dreq,
  output logic             rx_from_tx,
  output logic             tx_line_en
);

  localparam int HOLD_CYC = fair_cycles(CLK_KHZ);

  logic        rx_hit;
  logic        tx_hit;
  logic        cond;
  dma_owner_e  owner;
  loop_route_t route;

  assign owner = dma_owner_e'(chan_tx);

  ir_dma_thresh #(
    .DEPTH_SMALL (DEPTH_SMALL),
    .DEPTH_LARGE (DEPTH_LARGE),
    .RX_THR_LO   (RX_THR_LO),
    .RX_THR_HI   (RX_THR_HI),
    .TX_THR_S0   (TX_THR_S0),
    .TX_THR_S1   (TX_THR_S1),
    .TX_THR_L0   (TX_THR_L0),
    .TX_THR_L1   (TX_THR_L1),
    .LVL_W       (LVL_W)
  ) u_thresh (
    .rx_level (rx_level),
    .tx_level (tx_level),
    .deep     (deep),
    .thr_sel  (thr_sel),
    .rx_hit   (rx_hit),
    .tx_hit   (tx_hit)
  );

  assign cond = (owner == CH_TX) ? tx_hit : rx_hit;

  ir_dma_fair #(
    .HOLD_CYC (HOLD_CYC)
  ) u_fair (
    .clk     (clk),
    .rst     (rst),
    .cond    (cond),
    .fair_en (!fair_off),
    .dreq    (dreq)
  );

  ir_dma_route u_route (
    .clk      (clk),
    .rst      (rst),
    .loop_all (loop_all),
    .owner    (owner),
    .route    (route)
  );

  assign rx_from_tx = route.rx_from_tx;
  assign tx_line_en = route.tx_line_en;

endmodule

// File: rtl/ir_dma_req_chk.sv
module ir_dma_req_chk #(
  parameter int CLK_KHZ = 24000,
  parameter int LVL_W   = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_level,
  input logic             deep,
  input logic             thr_sel,
  input logic             fair_off,
  input logic             chan_tx,
  input logic             loop_all,
  input logic             dreq,
  input logic             rx_from_tx,
  input logic             tx_line_en
);

  localparam int LIMIT = (CLK_KHZ * 105) / 10000;
  localparam int HW    = $clog2(LIMIT + 2);

  logic [HW-1:0] hi_run;
  logic [6:0]    rx_need;
  logic [6:0]    tx_need;
  logic [6:0]    tx_room;

  assign rx_need = thr_sel ? 7'd10 : 7'd4;
  assign tx_need = deep ? (thr_sel ? 7'd13 : 7'd23) : (thr_sel ? 7'd7 : 7'd13);
  assign tx_room = (deep ? 7'd32 : 7'd16) - 7'(tx_level);

  always_ff @(posedge clk) begin
    if (rst) hi_run <= '0;
    else     hi_run <= (dreq && !fair_off) ? hi_run + 1'b1 : '0;
  end

  // R1
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!dreq && !rx_from_tx && tx_line_en));

  // R2
  a_r2_rx_below: assert property (@(posedge clk) disable iff (rst)
    (!chan_tx && (7'(rx_level) < rx_need)) |=> !dreq);

  // R3
  a_r3_tx_below: assert property (@(posedge clk) disable iff (rst)
    (chan_tx && (tx_room < tx_need)) |=> !dreq);

  // R6
  a_r6_fair_limit: assert property (@(posedge clk) disable iff (rst)
    dreq |-> (hi_run < HW'(LIMIT)));

  // R7
  a_r7_no_limit: assert property (@(posedge clk) disable iff (rst)
    (fair_off && !chan_tx && (7'(rx_level) >= rx_need)) |=> dreq);

  // R8
  a_r8_loop_route: assert property (@(posedge clk) disable iff (rst)
    loop_all |=> rx_from_tx);

  // R9
  a_r9_line_on: assert property (@(posedge clk) disable iff (rst)
    !loop_all |=> tx_line_en);

endmodule

bind ir_dma_req ir_dma_req_chk #(.CLK_KHZ(CLK_KHZ), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/ir_dma_req_test.sv
module ir_dma_req_test;

  localparam int CLK_PERIOD = 10;
  localparam int FAIR       = 252;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] rx_level, tx_level;
  logic       deep, thr_sel, fair_off, chan_tx, loop_all;
  logic       dreq, rx_from_tx, tx_line_en;

  int n_chk  = 0;
  int n_fail = 0;

  bit m_dreq = 1'b0;
  int m_cnt  = 0;
  bit m_rft  = 1'b0;
  bit m_len  = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_dma_req uut (
    .clk, .rst, .rx_level, .tx_level, .deep, .thr_sel, .fair_off,
    .chan_tx, .loop_all, .dreq, .rx_from_tx, .tx_line_en
  );

  function automatic int rx_thr_f(bit ts);
    return ts ? 10 : 4;
  endfunction

  function automatic int tx_thr_f(bit dp, bit ts);
    if (dp) return ts ? 13 : 23;
    return ts ? 7 : 13;
  endfunction

  function automatic bit cond_f(int rxl, int txl, bit dp, bit ts, bit ct);
    int depth = dp ? 32 : 16;
    if (ct) return (depth - txl) >= tx_thr_f(dp, ts);
    return rxl >= rx_thr_f(ts);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negative edge: drive, pass one rising edge, check at the next negative edge.
  task automatic step(int rxl, int txl, bit dp, bit ts, bit fo, bit ct, bit lb, string tag);
    bit    c, nd;
    int    nc;
    string dtag = tag;
    rx_level = 6'(rxl); tx_level = 6'(txl);
    deep = dp; thr_sel = ts; fair_off = fo; chan_tx = ct; loop_all = lb;
    c = cond_f(rxl, txl, dp, ts, ct);
    if (m_dreq && !fo && m_cnt == FAIR - 1) begin
      nd = 1'b0; nc = 0; dtag = "R6";
    end else begin
      nd = c;
      nc = (m_dreq && c && !fo) ? m_cnt + 1 : 0;
    end
    m_dreq = nd; m_cnt = nc;
    m_rft = lb;
    m_len = !lb || ct;
    @(negedge clk);
    check(dtag, int'(dreq), int'(m_dreq));
    check("R8", int'(rx_from_tx), int'(m_rft));
    check("R9", int'(tx_line_en), int'(m_len));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    rx_level = '0; tx_level = '0;
    deep = 0; thr_sel = 0; fair_off = 0; chan_tx = 0; loop_all = 0;
    repeat (3) @(negedge clk);
    check("R1", int'(dreq), 0);
    check("R1", int'(rx_from_tx), 0);
    check("R1", int'(tx_line_en), 1);
    rst = 1'b0;

    // R2 receive thresholds at their edges, both depths
    for (int dp = 0; dp < 2; dp++) begin
      step(3, 0, dp[0], 0, 1, 0, 0, "R2");
      step(4, 0, dp[0], 0, 1, 0, 0, "R2");
      step(9, 0, dp[0], 1, 1, 0, 0, "R2");
      step(10, 0, dp[0], 1, 1, 0, 0, "R2");
    end
    // R10 drop one clock after the condition clears
    step(2, 0, 0, 0, 1, 0, 0, "R10");

    // R3 and R4 transmit table edges (free = depth - level)
    step(3, 3, 0, 0, 1, 1, 0, "R4");
    step(3, 4, 0, 0, 1, 1, 0, "R4");
    step(3, 9, 0, 1, 1, 1, 0, "R4");
    step(3, 10, 0, 1, 1, 1, 0, "R4");
    step(3, 9, 1, 0, 1, 1, 0, "R4");
    step(3, 10, 1, 0, 1, 1, 0, "R4");
    step(3, 19, 1, 1, 1, 1, 0, "R4");
    step(3, 20, 1, 1, 1, 1, 0, "R4");
    step(3, 0, 1, 1, 1, 1, 0, "R3");

    // R5 the direction without the channel is ignored
    for (int i = 0; i < 12; i++) step(0, (i * 3) % 33, 1, 0, 1, 0, 0, "R5");
    for (int i = 0; i < 12; i++) step((i * 5) % 33, 32, 1, 0, 1, 1, 0, "R5");

    // R6 long hold with fairness on: forced release and reassert
    for (int i = 0; i < 2 * FAIR + 10; i++) step(16, 0, 0, 0, 0, 0, 0, "R6");
    // R7 long hold with fairness off
    for (int i = 0; i < FAIR + 20; i++) step(16, 0, 0, 0, 1, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 0, 0, "R10");

    // R8 and R9 loopback routing
    step(0, 0, 0, 0, 1, 0, 1, "R9");
    step(0, 0, 0, 0, 1, 1, 1, "R9");
    step(0, 0, 0, 0, 1, 1, 0, "R8");

    // Random mix; levels never exceed the selected depth
    for (int i = 0; i < 2000; i++) begin
      bit dp = 1'($urandom_range(0, 1));
      int d  = dp ? 32 : 16;
      bit ct = 1'($urandom_range(0, 1));
      step($urandom_range(0, d), $urandom_range(0, d), dp,
           1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0),
           ct, 1'($urandom_range(0, 1)), ct ? "R3" : "R2");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule